// File: doc/BRIEF.md
# Banked Search-Window Pixel Memory

This block holds a two-dimensional window of 8-bit reference pixels spread over a set of memory banks. Each pixel column has a bank of its own, and the pixel row is the word address inside that bank. Several pixels can therefore be read in one cycle whenever they sit in different banks. A read request carries up to four lanes, each a (column, row) pair, with a lane-enable mask. The block finds the lanes that collide on a bank and spreads the group over as many cycles as it needs. It returns each pixel one cycle after its lane is issued, with a per-lane valid flag.

The request side is valid/ready. A group is accepted in the cycle where `rq_valid` and `rq_ready` are both high. While `rq_valid` is high and `rq_ready` is low, the requester must hold `rq_mask`, `rq_col` and `rq_row` unchanged. `rq_ready` is high only in the cycle that issues the last lanes still waiting. The response side has no ready: responses cannot be back-pressured, and the consumer must take each one in the cycle it appears. A separate write port loads one pixel per cycle, so the window can be filled row by row.

Top module: `swin_bank_mem`

## Requirements
- R1: A pixel written at column c and row r (c < 6, r < 12) is stored in bank c at address r. A later read lane at (c, r) returns that pixel.
- R2: A lane's data appears on `rsp_data` in the cycle after the cycle that issues the lane. `rsp_lane_vld` bit l is high only for lanes issued in that earlier cycle, and `rsp_valid` is high when any lane bit is high.
- R3: A group whose enabled in-range lanes all use different banks has `rq_ready` high in its first cycle and is served by one response.
- R4: When enabled lanes share a bank at different rows, the group is a conflict and `rq_ready` stays low in its first cycle. In each cycle, each bank serves the row of its lowest-numbered waiting lane, so lanes are served in ascending lane order.
- R5: Enabled lanes that use the same bank and the same row are merged into one access, and all of them receive the pixel in the same response.
- R6: The number of cycles a group with a nonzero mask takes, up to and including the `rq_ready` cycle, is the largest number of distinct in-range rows requested from any single bank, and at least one.
- R7: A lane with column >= 6 or row >= 12 is issued in the group's first cycle. Its data is zero, and `rsp_err` is high in that response.
- R8: A write with column >= 6 or row >= 12 is ignored. A read and a write to the same location in the same cycle return the old pixel.
- R9: Lanes whose bit in `rq_mask` is 0 are never marked valid in a response. A group with an all-zero mask is accepted at once and produces no response.
- R10: After reset, `rsp_valid`, `rsp_lane_vld` and `rsp_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one pixel this cycle |
| wr_col | input | 3 | Write column (bank) |
| wr_row | input | 4 | Write row (address) |
| wr_data | input | 8 | Write pixel |
| rq_valid | input | 1 | Read group present |
| rq_ready | output | 1 | Group fully issued this cycle |
| rq_mask | input | 4 | Lane enables |
| rq_col | input | 12 | Per-lane column, lane l at bits [3l+2:3l] |
| rq_row | input | 16 | Per-lane row, lane l at bits [4l+3:4l] |
| rsp_valid | output | 1 | Response carries at least one lane |
| rsp_lane_vld | output | 4 | Lanes carried by this response |
| rsp_data | output | 32 | Per-lane pixel, lane l at bits [8l+7:8l] |
| rsp_err | output | 1 | An out-of-range lane is in this response |

## Verification
The assertions assume that the requester holds mask, columns and rows unchanged while a group waits for `rq_ready`. The conflict and error checks are evaluated in a group's first cycle, and they depend on this. The bench drives each group at a falling edge and leaves it untouched until it has seen `rq_ready`. It then drops `rq_valid` for at least one cycle. Random groups mix in-range and out-of-range coordinates and are biased toward a few columns so that conflicts and merges occur often.

// File: rtl/swin_pkg.sv
package swin_pkg;
  typedef logic [7:0] pix_t;
  localparam int unsigned LANES_DEF = 4;
endpackage

// File: rtl/swin_bank.sv
module swin_bank #(
  parameter int DEPTH = 12,
  parameter int AW    = 4,
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [PIX_W-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [PIX_W-1:0] rdata
);
  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && 32'(waddr) < DEPTH) mem[waddr] <= wdata;
    if (re && 32'(raddr) < DEPTH) rdata <= mem[raddr];
  end
endmodule

// File: rtl/swin_conflict_arb.sv
module swin_conflict_arb #(
  parameter int NUM_BANKS = 6,
  parameter int DEPTH     = 12,
  parameter int LANES     = 4,
  parameter int COL_W     = 3,
  parameter int ROW_W     = 4
) (
  input  logic [LANES-1:0]              pending,
  input  logic [LANES-1:0][COL_W-1:0]   col,
  input  logic [LANES-1:0][ROW_W-1:0]   row,
  output logic [NUM_BANKS-1:0]          bank_en,
  output logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row,
  output logic [LANES-1:0]              lane_oor,
  output logic [LANES-1:0]              issue
);
  always_comb begin
    for (int l = 0; l < LANES; l++)
      lane_oor[l] = (32'(col[l]) >= NUM_BANKS) || (32'(row[l]) >= DEPTH);
  end

  // Per bank: the lowest waiting in-range lane decides the row served.
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      bank_en[b]  = 1'b0;
      bank_row[b] = '0;
      for (int l = LANES - 1; l >= 0; l--) begin
        if (pending[l] && !lane_oor[l] && col[l] == COL_W'(b)) begin
          bank_en[b]  = 1'b1;
          bank_row[b] = row[l];
        end
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      logic hit;
      hit = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++)
        if (bank_en[b] && col[l] == COL_W'(b) && bank_row[b] == row[l]) hit = 1'b1;
      issue[l] = pending[l] && (lane_oor[l] || hit);
    end
  end
endmodule

// File: rtl/swin_bank_mem.sv
module swin_bank_mem #(
  parameter int NUM_BANKS = 6,
  parameter int DEPTH     = 12,
  parameter int PIX_W     = 8,
  parameter int LANES     = swin_pkg::LANES_DEF,
  localparam int COL_W    = $clog2(NUM_BANKS + 1),
  localparam int ROW_W    = $clog2(DEPTH + 1),
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [COL_W-1:0]              wr_col,
  input  logic [ROW_W-1:0]              wr_row,
  input  logic [PIX_W-1:0]              wr_data,
  input  logic                          rq_valid,
  output logic                          rq_ready,
  input  logic [LANES-1:0]              rq_mask,
  input  logic [LANES-1:0][COL_W-1:0]   rq_col,
  input  logic [LANES-1:0][ROW_W-1:0]   rq_row,
  output logic                          rsp_valid,
  output logic [LANES-1:0]              rsp_lane_vld,
  output logic [LANES-1:0][PIX_W-1:0]   rsp_data,
  output logic                          rsp_err
);
  logic [LANES-1:0] served_q, pending, issue, lane_oor;
  logic [NUM_BANKS-1:0] bank_en;
  logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row;
  logic [NUM_BANKS-1:0][PIX_W-1:0] bank_rdata;
  logic [LANES-1:0][COL_W-1:0] lane_bank_q;
  logic [LANES-1:0] lane_oor_q;

  assign pending  = rq_valid ? (rq_mask & ~served_q) : '0;
  assign rq_ready = ((pending & ~issue) == '0);

  swin_conflict_arb #(
    .NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH), .LANES(LANES),
    .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_arb (
    .pending(pending), .col(rq_col), .row(rq_row),
    .bank_en(bank_en), .bank_row(bank_row),
    .lane_oor(lane_oor), .issue(issue)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_en && wr_col == COL_W'(b) && 32'(wr_row) < DEPTH;
    swin_bank #(.DEPTH(DEPTH), .AW(AW), .PIX_W(PIX_W)) u_bank (
      .clk(clk), .we(bank_we), .waddr(wr_row[AW-1:0]), .wdata(wr_data),
      .re(bank_en[b]), .raddr(bank_row[b][AW-1:0]), .rdata(bank_rdata[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      served_q     <= '0;
      rsp_valid    <= 1'b0;
      rsp_lane_vld <= '0;
      rsp_err      <= 1'b0;
      lane_oor_q   <= '0;
      lane_bank_q  <= '0;
    end else begin
      if (rq_valid) served_q <= rq_ready ? '0 : (served_q | issue);
      rsp_valid    <= |issue;
      rsp_lane_vld <= issue;
      rsp_err      <= |(issue & lane_oor);
      lane_oor_q   <= lane_oor;
      lane_bank_q  <= rq_col;
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      rsp_data[l] = '0;
      for (int b = 0; b < NUM_BANKS; b++)
        if (rsp_lane_vld[l] && !lane_oor_q[l] && lane_bank_q[l] == COL_W'(b))
          rsp_data[l] = bank_rdata[b];
    end
  end
endmodule

// File: rtl/swin_bank_mem_chk.sv
module swin_bank_mem_chk #(
  parameter int NUM_BANKS = 6,
  parameter int DEPTH     = 12,
  parameter int LANES     = 4,
  parameter int COL_W     = 3,
  parameter int ROW_W     = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        rq_valid,
  input logic                        rq_ready,
  input logic [LANES-1:0]            rq_mask,
  input logic [LANES-1:0][COL_W-1:0] rq_col,
  input logic [LANES-1:0][ROW_W-1:0] rq_row,
  input logic                        rsp_valid,
  input logic [LANES-1:0]            rsp_lane_vld,
  input logic                        rsp_err
);
  logic conflict, any_oor, mid_q;

  always_comb begin
    conflict = 1'b0;
    any_oor  = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (rq_mask[i] && (32'(rq_col[i]) >= NUM_BANKS || 32'(rq_row[i]) >= DEPTH))
        any_oor = 1'b1;
      for (int j = i + 1; j < LANES; j++)
        if (rq_mask[i] && rq_mask[j] && rq_col[i] == rq_col[j] &&
            rq_row[i] != rq_row[j] && 32'(rq_col[i]) < NUM_BANKS &&
            32'(rq_row[i]) < DEPTH && 32'(rq_row[j]) < DEPTH)
          conflict = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mid_q <= 1'b0;
    else        mid_q <= rq_valid && !rq_ready;
  end

  AST_NO_CONFLICT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && !conflict) |-> rq_ready); // R3
  AST_CONFLICT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && !mid_q && conflict) |-> !rq_ready); // R4
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rq_valid)); // R2
  AST_MASKED_LANES_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid |=> ((rsp_lane_vld & ~$past(rq_mask)) == '0)); // R9
  AST_OOR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && !mid_q && any_oor) |=> rsp_err); // R7
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $rose(rst_n) |-> (!rsp_valid && rsp_lane_vld == '0 && !rsp_err)); // R10
endmodule

bind swin_bank_mem swin_bank_mem_chk #(
  .NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH), .LANES(LANES),
  .COL_W(COL_W), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rq_valid(rq_valid), .rq_ready(rq_ready),
  .rq_mask(rq_mask), .rq_col(rq_col), .rq_row(rq_row),
  .rsp_valid(rsp_valid), .rsp_lane_vld(rsp_lane_vld), .rsp_err(rsp_err)
);

// File: tb/swin_bank_mem_tb.sv
module swin_bank_mem_tb;
  localparam int NB = 6, DP = 12, L = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_col = '0;
  logic [3:0] wr_row = '0;
  logic [7:0] wr_data = '0;
  logic rq_valid = 1'b0, rq_ready;
  logic [3:0] rq_mask = '0;
  logic [3:0][2:0] rq_col = '0;
  logic [3:0][3:0] rq_row = '0;
  logic rsp_valid, rsp_err;
  logic [3:0] rsp_lane_vld;
  logic [3:0][7:0] rsp_data;

  int vectors = 0, miscompares = 0, cycles = 0;
  logic [7:0] refm [NB][DP];

  always #2.5 clk = ~clk;

  swin_bank_mem u_dut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit oor(input int c, input int r);
    return (c >= NB) || (r >= DP);
  endfunction

  function automatic int exp_cycles(input logic [3:0] m, input logic [3:0][2:0] c,
                                    input logic [3:0][3:0] r);
    int best = 1;
    for (int b = 0; b < NB; b++) begin
      int n = 0;
      for (int i = 0; i < L; i++) begin
        bit seen = 0;
        if (!m[i] || oor(c[i], r[i]) || c[i] != b) continue;
        for (int j = 0; j < i; j++)
          if (m[j] && c[j] == b && r[j] == r[i]) seen = 1;
        if (!seen) n++;
      end
      if (n > best) best = n;
    end
    return best;
  endfunction

  task automatic wr(input int c, input int r, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_col = 3'(c); wr_row = 4'(r); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (!oor(c, r)) refm[c][r] = d;
  endtask

  // first_exp < 0 skips the first-response lane-mask check
  task automatic group(input logic [3:0] m, input logic [3:0][2:0] c,
                       input logic [3:0][3:0] r, input int first_exp, input string tag);
    logic [3:0] got = '0;
    int n = 0;
    bit eerr = 0, rdy;
    for (int i = 0; i < L; i++) if (m[i] && oor(c[i], r[i])) eerr = 1;
    @(negedge clk);
    rq_valid = 1; rq_mask = m; rq_col = c; rq_row = r;
    #1;
    do begin
      rdy = rq_ready;
      n++;
      @(negedge clk);
      chk({tag, " R2 rsp_valid"}, int'(rsp_valid), 1);
      if (n == 1) begin
        chk({tag, " R7 rsp_err"}, int'(rsp_err), int'(eerr));
        if (first_exp >= 0) chk({tag, " R4 first lanes"}, int'(rsp_lane_vld), first_exp);
      end
      for (int i = 0; i < L; i++) if (rsp_lane_vld[i]) begin
        chk({tag, " R9 lane enabled"}, int'(m[i]), 1);
        chk({tag, " R2 lane once"}, int'(got[i]), 0);
        got[i] = 1;
        chk({tag, " R1 data"}, int'(rsp_data[i]),
            oor(c[i], r[i]) ? 0 : int'(refm[c[i]][r[i]]));
      end
    end while (!rdy && n < 10);
    rq_valid = 0;
    chk({tag, " R6 cycles"}, n, exp_cycles(m, c, r));
    chk({tag, " R5 all lanes served"}, int'(got), int'(m));
  endtask

  initial begin
    logic [3:0][2:0] c;
    logic [3:0][3:0] r;
    void'($urandom(1234));
    for (int b = 0; b < NB; b++) for (int a = 0; a < DP; a++) refm[b][a] = 8'(b * 16 + a);
    repeat (3) @(negedge clk);
    chk("R10 rsp_valid", int'(rsp_valid), 0);
    chk("R10 lanes", int'(rsp_lane_vld), 0);
    chk("R10 err", int'(rsp_err), 0);
    rst_n = 1;
    // R1: fill window row by row
    for (int a = 0; a < DP; a++) for (int b = 0; b < NB; b++) wr(b, a, 8'(b * 16 + a));
    // R3: diagonal run, distinct banks
    c = {3'd4, 3'd3, 3'd2, 3'd1}; r = {4'd6, 4'd5, 4'd4, 4'd3};
    group(4'hF, c, r, 15, "diag");
    // R4: 2x2 square, lanes 0,1 first
    c = {3'd3, 3'd2, 3'd3, 3'd2}; r = {4'd6, 4'd6, 4'd5, 4'd5};
    group(4'hF, c, r, 3, "square");
    // R4: one column, four rows, lane order
    c = {3'd0, 3'd0, 3'd0, 3'd0}; r = {4'd1, 4'd9, 4'd2, 4'd7};
    group(4'hF, c, r, 1, "column");
    // R5: merge same bank same row
    c = {3'd5, 3'd5, 3'd1, 3'd5}; r = {4'd2, 4'd2, 4'd0, 4'd2};
    group(4'hF, c, r, 15, "merge");
    // R7: out-of-range column and row
    c = {3'd7, 3'd2, 3'd6, 3'd2}; r = {4'd0, 4'd13, 4'd0, 4'd3};
    group(4'hF, c, r, 15, "oor");
    // R9: masked lanes that would conflict are ignored
    c = {3'd1, 3'd1, 3'd1, 3'd1}; r = {4'd1, 4'd2, 4'd3, 4'd4};
    group(4'b0100, c, r, 4, "masked");
    // R9: empty mask
    @(negedge clk);
    rq_valid = 1; rq_mask = 0; #1;
    chk("R9 empty mask ready", int'(rq_ready), 1);
    @(negedge clk);
    rq_valid = 0;
    chk("R9 empty mask no rsp", int'(rsp_valid), 0);
    // R8: out-of-range write ignored, read-during-write returns old
    wr(7, 3, 8'hAA);
    wr(2, 14, 8'hBB);
    @(negedge clk);
    wr_en = 1; wr_col = 3'd4; wr_row = 4'd8; wr_data = 8'h5C;
    rq_valid = 1; rq_mask = 4'b0001; rq_col = {4{3'd4}}; rq_row = {4{4'd8}};
    @(negedge clk);
    wr_en = 0; rq_valid = 0;
    chk("R8 read old on collision", int'(rsp_data[0]), int'(refm[4][8]));
    refm[4][8] = 8'h5C;
    c = {3'd4, 3'd4, 3'd4, 3'd4}; r = {4'd8, 4'd8, 4'd8, 4'd8};
    group(4'hF, c, r, 15, "R8 new value");
    // random groups mixed with writes
    for (int k = 0; k < 400; k++) begin
      logic [3:0] m;
      if ($urandom % 4 == 0) wr($urandom % 7, $urandom % 13, 8'($urandom));
      m = 4'($urandom);
      if (m == 0) m = 4'b1000;
      for (int i = 0; i < L; i++) begin
        c[i] = ($urandom % 10 == 0) ? 3'($urandom % 8) : 3'($urandom % 3);
        r[i] = ($urandom % 10 == 0) ? 4'($urandom % 16) : 4'($urandom % 4);
      end
      group(m, c, r, -1, "random R6");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule